// File: doc/BRIEF.md
# Open-Page Bank Timing Controller

This block accepts one read request at a time over a valid/ready handshake and turns it into the command sequence for a single SDRAM-style bank. It keeps the bank open after each access and remembers which row is open. Each new request is sorted into one of three cases. If the same row is already open, the block issues only a column read. If no row is open, it activates the row and then reads. If a different row is open, it closes the bank, activates the new row and then reads.

Four cycle timings are supplied as inputs: CAS latency, activate-to-read delay, precharge time and minimum activate-to-activate spacing. They are captured when a request is accepted. The block signals the arrival of read data with a one-cycle pulse. With that pulse it reports the page case of the request and the number of cycles spent since acceptance, so the cost of hits, empties and conflicts can be measured directly.

Top module: `dram_page_ctrl`

## Requirements
- R1: A request whose row equals the open row issues READ (and no ACTIVATE or PRECHARGE) in the cycle it is accepted, and its data-valid pulse comes CL cycles later.
- R2: After reset no row is open. The first request issues ACTIVATE in its acceptance cycle, and its READ comes exactly tRCD cycles after that ACTIVATE.
- R3: `rd_valid` is high for exactly one cycle, CL cycles after the cycle in which READ was issued.
- R4: A request to a row other than the open one issues PRECHARGE in its acceptance cycle. ACTIVATE follows no earlier than tRP cycles later, and READ comes tRCD cycles after that ACTIVATE.
- R5: Two ACTIVATE commands are at least tRC cycles apart, where tRC is the value captured with the request that issued the earlier ACTIVATE. When tRC is the binding constraint, ACTIVATE is issued exactly tRC cycles after the earlier one.
- R6: During the `rd_valid` pulse, `rd_class` gives the page case: 2'b00 for a hit, 2'b01 for empty, 2'b10 for a conflict. `rd_latency` gives the distance from the acceptance cycle to the pulse cycle, which is CL for a hit, tRCD+CL for empty and tRP+tRCD+CL for a conflict, stretched as needed by R5.
- R7: `req_ready` is high after reset. It is low from the cycle after acceptance through the `rd_valid` cycle, and high again in the following cycle.
- R8: The four timing inputs are captured at acceptance. Changing them while a request is in flight does not alter that request's command cycles or latency.
- R9: A timing input of 0 behaves exactly as 1.
- R10: At most one command is issued per cycle, and `cmd_row` carries the request's row whenever ACTIVATE or READ is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_row | input | ROW_W | Row addressed by the request |
| t_cl | input | TW | CAS latency in cycles |
| t_rcd | input | TW | Activate-to-read delay in cycles |
| t_rp | input | TW | Precharge time in cycles |
| t_rc | input | TW | Minimum activate-to-activate spacing in cycles |
| cmd_act | output | 1 | ACTIVATE issued this cycle |
| cmd_rd | output | 1 | READ issued this cycle |
| cmd_pre | output | 1 | PRECHARGE issued this cycle |
| cmd_row | output | ROW_W | Row for ACTIVATE/READ |
| rd_valid | output | 1 | One-cycle read-data-valid pulse |
| rd_class | output | 2 | Page case of the completed request |
| rd_latency | output | LAT_W | Cycles from acceptance to rd_valid |

## Verification
The block may record the wrong open row or lose the open flag. The next request then shows the wrong `rd_class` and a command pattern that is off by one or two commands, such as a PRECHARGE where only a READ belongs. This is visible in that request's acceptance cycle. A wrong timing counter moves ACTIVATE, READ or the valid pulse by whole cycles, and `rd_latency` stops agreeing with the sum of the captured timings. A stale activate-spacing counter shows up only on a conflict issued soon after a previous ACTIVATE, as an ACTIVATE that comes too early or too late against tRC.

// File: rtl/dpc_pkg.sv
// Shared types for the open-page bank timing controller.
// Assumes: page codes are visible at the ports and must not be renumbered.
package dpc_pkg;

    typedef enum logic [1:0] {
        PG_HIT      = 2'b00,
        PG_EMPTY    = 2'b01,
        PG_CONFLICT = 2'b10
    } page_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ACTW = 2'b01,
        ST_RCDW = 2'b10,
        ST_CASW = 2'b11
    } seq_state_e;

endpackage

// File: rtl/dpc_row_tracker.sv
// Remembers whether the bank has an open row and which row it is,
// and classifies an incoming row against it.
// Assumes: ACTIVATE and PRECHARGE never fire in the same cycle.
module dpc_row_tracker
    import dpc_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] act_row,
    input  logic [ROW_W-1:0] req_row,
    output page_cls_e        page_cls
);

    logic             open_q;
    logic [ROW_W-1:0] open_row_q;

    // Track open/closed state and the open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
        end else if (act_fire) begin
            open_q     <= 1'b1;
            open_row_q <= act_row;
        end else if (pre_fire) begin
            open_q     <= 1'b0;
        end
    end

    // Sort the requested row into hit, empty or conflict.
    always_comb begin
        if (!open_q)                    page_cls = PG_EMPTY;
        else if (open_row_q == req_row) page_cls = PG_HIT;
        else                            page_cls = PG_CONFLICT;
    end

    // R4
    pre_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |-> open_q);

    // R2
    act_needs_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !open_q);

endmodule

// File: rtl/dpc_rc_guard.sv
// Counts down the minimum activate-to-activate spacing after each ACTIVATE
// and reports when another ACTIVATE is allowed.
// Assumes: trc is already clamped to at least 1.
module dpc_rc_guard #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_fire,
    input  logic [TW-1:0] trc,
    output logic          act_ok
);

    logic [TW-1:0] rc_left_q;
    logic [TW-1:0] since_q;
    logic [TW-1:0] need_q;
    logic          seen_q;

    // Reload on ACTIVATE, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              rc_left_q <= '0;
        else if (act_fire)       rc_left_q <= trc - 1'b1;
        else if (rc_left_q != 0) rc_left_q <= rc_left_q - 1'b1;
    end

    assign act_ok = (rc_left_q == '0);

    // Independent saturating distance since last ACTIVATE, for checking only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            need_q  <= '0;
            seen_q  <= 1'b0;
        end else if (act_fire) begin
            since_q <= {{(TW-1){1'b0}}, 1'b1};
            need_q  <= trc;
            seen_q  <= 1'b1;
        end else if (since_q != {TW{1'b1}}) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R5
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && seen_q) |-> (since_q >= need_q));

endmodule

// File: rtl/dpc_seq.sv
// Command sequencer: accepts one request, issues PRECHARGE/ACTIVATE/READ
// at the captured timings and raises the data-valid pulse.
// Assumes: page_cls and act_ok come from the row tracker and spacing guard.
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int TW    = 4,
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [TW-1:0]    t_cl,
    input  logic [TW-1:0]    t_rcd,
    input  logic [TW-1:0]    t_rp,
    input  logic [TW-1:0]    t_rc,
    input  page_cls_e        page_cls,
    input  logic             act_ok,
    output logic             req_ready,
    output logic             cmd_act,
    output logic             cmd_rd,
    output logic             cmd_pre,
    output logic [ROW_W-1:0] cmd_row,
    output logic [TW-1:0]    trc_eff,
    output logic             rd_valid,
    output logic [1:0]       rd_class,
    output logic [LAT_W-1:0] rd_latency
);

    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    function automatic logic [TW-1:0] clamp1(input logic [TW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    seq_state_e       state_q;
    logic [TW-1:0]    cnt_q;
    logic [TW-1:0]    cl_q, rcd_q, rp_q, rc_q;
    logic [ROW_W-1:0] row_q;
    page_cls_e        cls_q;
    logic [LAT_W-1:0] lat_q;
    logic [TW-1:0]    cl_in, rcd_in, rp_in, rc_in;
    logic             accept;

    // Clamp raw timing inputs so that zero acts as one.
    always_comb begin
        cl_in  = clamp1(t_cl);
        rcd_in = clamp1(t_rcd);
        rp_in  = clamp1(t_rp);
        rc_in  = clamp1(t_rc);
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign trc_eff   = (state_q == ST_IDLE) ? rc_in : rc_q;
    assign cmd_row   = (state_q == ST_IDLE) ? req_row : row_q;

    // Decide which command, if any, goes out this cycle.
    always_comb begin
        cmd_act  = 1'b0;
        cmd_rd   = 1'b0;
        cmd_pre  = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                unique case (page_cls)
                    PG_HIT:   cmd_rd  = 1'b1;
                    PG_EMPTY: cmd_act = act_ok;
                    default:  cmd_pre = 1'b1;
                endcase
            end
            ST_ACTW: cmd_act  = (cnt_q == '0) && act_ok;
            ST_RCDW: cmd_rd   = (cnt_q == '0);
            default: rd_valid = (cnt_q == '0);
        endcase
    end

    // Advance the sequence and its wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    unique case (page_cls)
                        PG_HIT: begin
                            state_q <= ST_CASW;
                            cnt_q   <= cl_in - 1'b1;
                        end
                        PG_EMPTY: begin
                            state_q <= cmd_act ? ST_RCDW : ST_ACTW;
                            cnt_q   <= cmd_act ? rcd_in - 1'b1 : '0;
                        end
                        default: begin
                            state_q <= ST_ACTW;
                            cnt_q   <= rp_in - 1'b1;
                        end
                    endcase
                end
                ST_ACTW: begin
                    if (cmd_act) begin
                        state_q <= ST_RCDW;
                        cnt_q   <= rcd_q - 1'b1;
                    end else if (cnt_q != '0) begin
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                ST_RCDW: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_CASW;
                        cnt_q   <= cl_q - 1'b1;
                    end else begin
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    // Capture timings, row and page case at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q  <= ONE;
            rcd_q <= ONE;
            rp_q  <= ONE;
            rc_q  <= ONE;
            row_q <= '0;
            cls_q <= PG_EMPTY;
        end else if (accept) begin
            cl_q  <= cl_in;
            rcd_q <= rcd_in;
            rp_q  <= rp_in;
            rc_q  <= rc_in;
            row_q <= req_row;
            cls_q <= page_cls;
        end
    end

    // Count cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lat_q <= '0;
        else if (accept)             lat_q <= {{(LAT_W-1){1'b0}}, 1'b1};
        else if (state_q != ST_IDLE) lat_q <= lat_q + 1'b1;
    end

    assign rd_class   = cls_q;
    assign rd_latency = lat_q;

    // R7
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R7
    ready_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> req_ready);

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    latency_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_latency >= {{(LAT_W-TW){1'b0}}, cl_q}));

endmodule

// File: rtl/dram_page_ctrl.sv
// Top of the open-page bank timing controller: joins row tracker,
// activate-spacing guard and command sequencer.
// Assumes: a single bank, reads only, one request outstanding.
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int TW    = 4,
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [TW-1:0]    t_cl,
    input  logic [TW-1:0]    t_rcd,
    input  logic [TW-1:0]    t_rp,
    input  logic [TW-1:0]    t_rc,
    output logic             cmd_act,
    output logic             cmd_rd,
    output logic             cmd_pre,
    output logic [ROW_W-1:0] cmd_row,
    output logic             rd_valid,
    output logic [1:0]       rd_class,
    output logic [LAT_W-1:0] rd_latency
);

    page_cls_e     page_cls;
    logic          act_ok;
    logic [TW-1:0] trc_eff;

    dpc_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (cmd_act),
        .pre_fire (cmd_pre),
        .act_row  (cmd_row),
        .req_row  (req_row),
        .page_cls (page_cls)
    );

    dpc_rc_guard #(.TW(TW)) u_rc (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (cmd_act),
        .trc      (trc_eff),
        .act_ok   (act_ok)
    );

    dpc_seq #(.ROW_W(ROW_W), .TW(TW), .LAT_W(LAT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_row    (req_row),
        .t_cl       (t_cl),
        .t_rcd      (t_rcd),
        .t_rp       (t_rp),
        .t_rc       (t_rc),
        .page_cls   (page_cls),
        .act_ok     (act_ok),
        .req_ready  (req_ready),
        .cmd_act    (cmd_act),
        .cmd_rd     (cmd_rd),
        .cmd_pre    (cmd_pre),
        .cmd_row    (cmd_row),
        .trc_eff    (trc_eff),
        .rd_valid   (rd_valid),
        .rd_class   (rd_class),
        .rd_latency (rd_latency)
    );

    // R10
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_rd, cmd_pre}));

    // R1
    hit_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && page_cls == PG_HIT) |-> (cmd_rd && !cmd_act));

endmodule

// File: tb/tb_dram_page_ctrl.sv
`timescale 1ns/1ps
module tb_dram_page_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_row = '0;
    logic [3:0] t_cl = 4'd1, t_rcd = 4'd1, t_rp = 4'd1, t_rc = 4'd1;
    logic       cmd_act, cmd_rd, cmd_pre;
    logic [7:0] cmd_row;
    logic       rd_valid;
    logic [1:0] rd_class;
    logic [5:0] rd_latency;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    // bench-side model of the bank
    bit model_open = 0;
    int model_row  = 0;
    int deadline   = -1000;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_page_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .t_cl(t_cl), .t_rcd(t_rcd), .t_rp(t_rp), .t_rc(t_rc),
        .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_pre(cmd_pre), .cmd_row(cmd_row),
        .rd_valid(rd_valid), .rd_class(rd_class), .rd_latency(rd_latency)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int cl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Issue one request, watch every cycle, compare with model.
    task automatic run_req(input int row, input int cl, input int rcd, input int rp,
                           input int rc, input bit change_mid, input string tag);
        int ecl = cl1(cl), ercd = cl1(rcd), erp = cl1(rp), erc = cl1(rc);
        int ecls, eact, erd, epre, evalid, acc;
        int act_k = -1, rd_k = -1, pre_k = -1, val_k = -1, vcls = -1, vlat = -1;
        int row_bad = 0, multi = 0, rdy_bad = 0, pulse_ok;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        t_cl = cl[3:0]; t_rcd = rcd[3:0]; t_rp = rp[3:0]; t_rc = rc[3:0];
        req_row = row[7:0];
        req_valid = 1'b1;
        acc = cyc;
        eact = -1; epre = -1;
        if (!model_open) begin
            ecls = 1;
            eact = max2(0, deadline - acc);
            erd  = eact + ercd;
        end else if (model_row == row) begin
            ecls = 0;
            erd  = 0;
        end else begin
            ecls = 2;
            epre = 0;
            eact = max2(erp, deadline - acc);
            erd  = eact + ercd;
        end
        evalid = erd + ecl;
        for (int k = 0; k < 200 && val_k < 0; k++) begin
            if (k > 0) begin
                @(negedge clk);
                req_valid = 1'b0;
                if (change_mid) begin
                    t_cl = 4'd9; t_rcd = 4'd9; t_rp = 4'd9; t_rc = 4'd9;
                end
            end
            #1;
            if (k > 0 && req_ready) rdy_bad++;
            if (int'(cmd_act) + int'(cmd_rd) + int'(cmd_pre) > 1) multi++;
            if (cmd_act) begin act_k = k; if (cmd_row != row[7:0]) row_bad++; end
            if (cmd_rd)  begin rd_k = k;  if (cmd_row != row[7:0]) row_bad++; end
            if (cmd_pre) pre_k = k;
            if (rd_valid) begin val_k = k; vcls = rd_class; vlat = rd_latency; end
        end
        @(negedge clk); #1;
        pulse_ok = (!rd_valid && req_ready) ? 1 : 0;
        req_valid = 1'b0;
        // R1 R2 R4 R5: command placement
        chk(ecls == 0 ? "R1" : (ecls == 1 ? "R2" : "R4/R5"), {tag, " ACTIVATE cycle"}, act_k, eact);
        chk(ecls == 2 ? "R4" : "R1", {tag, " PRECHARGE cycle"}, pre_k, epre);
        chk(ecls == 0 ? "R1" : "R2", {tag, " READ cycle"}, rd_k, erd);
        // R3: pulse CL after READ, single cycle
        chk("R3", {tag, " READ-to-valid"}, val_k - rd_k, ecl);
        chk("R3", {tag, " pulse ends and ready returns"}, pulse_ok, 1);
        // R6: classification and latency report
        chk("R6", {tag, " class code"}, vcls, ecls);
        chk("R6", {tag, " reported latency"}, vlat, evalid);
        chk("R6", {tag, " observed latency"}, val_k, evalid);
        // R7: ready held low while busy
        chk("R7", {tag, " ready while busy"}, rdy_bad, 0);
        // R10: one command per cycle, row on ACT/READ
        chk("R10", {tag, " command overlap"}, multi, 0);
        chk("R10", {tag, " command row"}, row_bad, 0);
        if (eact >= 0) deadline = acc + eact + erc;
        model_open = 1;
        model_row  = row;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R7", "ready after reset", req_ready, 1);
        chk("R10", "no command after reset", int'(cmd_act) + int'(cmd_rd) + int'(cmd_pre), 0);
        chk("R3", "no valid after reset", rd_valid, 0);
    endtask

    task automatic test_empty_first();   run_req(5, 3, 2, 2, 1, 0, "R2 first access");   endtask
    task automatic test_hits();
        run_req(5, 2, 2, 2, 1, 0, "R1 hit CL2");
        run_req(5, 1, 3, 3, 1, 0, "R1 hit CL1");
    endtask
    task automatic test_conflict();      run_req(9, 2, 3, 3, 1, 0, "R4 conflict");       endtask
    task automatic test_trc();
        run_req(4, 1, 1, 1, 15, 0, "R5 setup");
        run_req(6, 1, 1, 1, 15, 0, "R5 stretched");
    endtask
    task automatic test_latch();
        run_req(6, 2, 2, 2, 1, 1, "R8 hit latch");
        run_req(7, 2, 2, 2, 1, 1, "R8 conflict latch");
    endtask
    task automatic test_zero();
        run_req(7, 0, 0, 0, 0, 0, "R9 zero hit");
        run_req(8, 0, 0, 0, 0, 0, "R9 zero conflict");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_empty_first();
        test_hits();
        test_conflict();
        test_trc();
        test_latch();
        test_zero();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule